// File: doc/BRIEF.md
# Nested Task Return Controller

This block keeps the control state that decides what a return-from-interrupt command does in a processor that can switch between hardware tasks. A task call records the caller in the callee's back-link register, enters the callee and marks it as nested. An interrupt entry saves the full flags word and a return address on a small frame stack that belongs to the running task. It then clears the trace, resume, virtual-mode and nesting flags, so the handler starts clean. When a return-from-interrupt command arrives, the nesting flag decides the outcome. If the flag is set, the block switches back to the parent task. If it is clear, the block pops a frame and resumes locally.

Because entry clears the nesting flag, a handler that runs inside a nested task returns to the interrupted code in that task. It does not leave for the parent. The local return restores the saved flags, and with them the nesting flag, so the next return-from-interrupt issued outside the handler goes back to the caller. The block takes one command per cycle. Every output is registered.

Top module: `ntask_ret_ctrl`

## Requirements
- R1: An accepted task call (cmd_op = 0) stores the running task index as the destination's back-link, makes cmd_task the current task and pulses task_sw in the cycle after the command.
- R2: After a task call, flags equals the destination's saved flags with bit 14 (nesting flag) set. Every task's saved flags start at FLAGS_INIT, which is 32'h0003_0102 by default.
- R3: A return command (cmd_op = 2) with flags bit 14 set switches to the back-linked task, pulses task_sw, leaves resume_addr unchanged and does not touch the frame stack.
- R4: A return command with flags bit 14 clear pops the top frame of the current task. It loads resume_addr from that frame, pulses norm_ret and keeps the current task.
- R5: An interrupt entry (cmd_op = 1) pushes the whole flags word and cmd_addr. It then clears bits 8, 14, 16 and 17 of flags and keeps every other bit.
- R6: A local return restores the complete popped flags word. When that word has bit 14 set, the next return command performs a task return.
- R7: On a task return, flags is reloaded with the value the resumed task held when it made its call.
- R8: Each task has a 4-entry frame stack. An interrupt entry on a full stack, or a local return on an empty stack, pulses fault with done low and changes no output state.
- R9: A task call whose destination is the current task, or any task on the active call chain, pulses fault and is ignored.
- R10: Command code 3 is reserved. It pulses fault and is ignored.
- R11: Each accepted command gives a single done pulse in the following cycle. task_sw and norm_ret are never high together, and done is low in cycles where no command was given.
- R12: After reset the current task is 0, flags equals FLAGS_INIT, resume_addr is 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 task call, 1 interrupt entry, 2 return, 3 reserved |
| cmd_task | input | TW | Destination task of a call |
| cmd_addr | input | AW | Return address saved by an interrupt entry |
| cur_task | output | TW | Currently running task |
| flags | output | 32 | Flags word of the running context |
| resume_addr | output | AW | Address restored by the last local return |
| done | output | 1 | Pulse: the previous command was accepted |
| task_sw | output | 1 | Pulse: a task call or task return took place |
| norm_ret | output | 1 | Pulse: a local return popped a frame |
| fault | output | 1 | Pulse: the previous command was rejected |

## Verification
The hardest situation to reach is a return-from-interrupt that has to be resolved locally even though the running task is nested. A second case is harder still: a parent task that was itself interrupted, whose saved flags have the nesting flag clear, has to be resumed by a task return. The stimulus gets there with command sequences. It calls into a task, takes an interrupt, calls a grandchild from inside the handler, then unwinds with three returns in a row. Each return is checked for the path it took and for the flags it restored. A separate sequence fills one task's frame stack to the brim, and then drains it one pop past empty.

// File: rtl/ntask_pkg.sv
package ntask_pkg;
  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_INT  = 2'd1,
    OP_IRET = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam int FW      = 32;
  localparam int TF_BIT  = 8;
  localparam int NT_BIT  = 14;
  localparam int RF_BIT  = 16;
  localparam int VM_BIT  = 17;

  localparam logic [FW-1:0] NT_MASK    = FW'(1) << NT_BIT;
  localparam logic [FW-1:0] ENTRY_CLR  = (FW'(1) << TF_BIT) | (FW'(1) << NT_BIT) |
                                         (FW'(1) << RF_BIT) | (FW'(1) << VM_BIT);
endpackage

// File: rtl/ntask_cmd_decode.sv
module ntask_cmd_decode
  import ntask_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       nt_set,
  input  logic       dest_busy,
  input  logic       stk_full,
  input  logic       stk_empty,
  output logic       act_call,
  output logic       act_int,
  output logic       act_tret,
  output logic       act_nret,
  output logic       act_fault
);
  always_comb begin
    act_call  = 1'b0;
    act_int   = 1'b0;
    act_tret  = 1'b0;
    act_nret  = 1'b0;
    act_fault = 1'b0;
    if (cmd_valid) begin
      unique case (op_e'(cmd_op))
        OP_CALL: if (dest_busy) act_fault = 1'b1; else act_call = 1'b1;
        OP_INT:  if (stk_full)  act_fault = 1'b1; else act_int  = 1'b1;
        OP_IRET: begin
          if (nt_set)         act_tret  = 1'b1;
          else if (stk_empty) act_fault = 1'b1;
          else                act_nret  = 1'b1;
        end
        default: act_fault = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ntask_frame_mem.sv
module ntask_frame_mem #(
  parameter int NTASK = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 48,
  localparam int TW   = $clog2(NTASK),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int MW   = TW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [TW-1:0] task_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [NTASK*DEPTH];
  logic [CW-1:0] cnt_q [NTASK];
  logic [CW-1:0] cur_cnt;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [MW-1:0] wr_idx, rd_idx;

  assign cur_cnt = cnt_q[task_sel];
  assign full    = (cur_cnt == CW'(DEPTH));
  assign empty   = (cur_cnt == '0);
  assign wr_ptr  = PW'(cur_cnt);
  assign rd_ptr  = PW'(cur_cnt) - PW'(1);
  assign wr_idx  = {task_sel, wr_ptr};
  assign rd_idx  = {task_sel, rd_ptr};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTASK; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NTASK; i++) begin
        if (task_sel == TW'(i)) begin
          if (push && !full)       cnt_q[i] <= cnt_q[i] + CW'(1);
          else if (pop && !empty)  cnt_q[i] <= cnt_q[i] - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  assign rdata = mem[rd_idx];
endmodule

// File: rtl/ntask_task_table.sv
module ntask_task_table
  import ntask_pkg::*;
#(
  parameter int NTASK = 8,
  parameter logic [31:0] FLAGS_INIT = 32'h0003_0102,
  localparam int TW = $clog2(NTASK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cur_task,
  input  logic [TW-1:0] dest_task,
  input  logic [FW-1:0] cur_flags,
  input  logic          call_we,
  input  logic          tret_we,
  output logic [TW-1:0] link_of_cur,
  output logic [FW-1:0] dest_flags,
  output logic [FW-1:0] parent_flags,
  output logic          dest_busy
);
  logic [TW-1:0] link_q  [NTASK];
  logic [FW-1:0] fsave_q [NTASK];
  logic [NTASK-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTASK; i++) begin
        link_q[i]  <= '0;
        fsave_q[i] <= FLAGS_INIT;
      end
      busy_q <= NTASK'(1);
    end else if (call_we) begin
      link_q[dest_task]  <= cur_task;
      fsave_q[cur_task]  <= cur_flags;
      busy_q[dest_task]  <= 1'b1;
    end else if (tret_we) begin
      fsave_q[cur_task]  <= cur_flags & ~NT_MASK;
      busy_q[cur_task]   <= 1'b0;
    end
  end

  assign link_of_cur  = link_q[cur_task];
  assign dest_flags   = fsave_q[dest_task];
  assign parent_flags = fsave_q[link_of_cur];
  assign dest_busy    = busy_q[dest_task];
endmodule

// File: rtl/ntask_ret_ctrl.sv
module ntask_ret_ctrl
  import ntask_pkg::*;
#(
  parameter int NTASK = 8,
  parameter int STK_DEPTH = 4,
  parameter int AW = 16,
  parameter logic [31:0] FLAGS_INIT = 32'h0003_0102,
  localparam int TW = $clog2(NTASK),
  localparam int DW = FW + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [TW-1:0] cmd_task,
  input  logic [AW-1:0] cmd_addr,
  output logic [TW-1:0] cur_task,
  output logic [31:0]   flags,
  output logic [AW-1:0] resume_addr,
  output logic          done,
  output logic          task_sw,
  output logic          norm_ret,
  output logic          fault
);
  logic [TW-1:0] cur_q;
  logic [FW-1:0] flags_q;
  logic [AW-1:0] resume_q;
  logic          done_q, sw_q, nret_q, fault_q;

  logic act_call, act_int, act_tret, act_nret, act_fault;
  logic stk_full, stk_empty, dest_busy;
  logic [DW-1:0] frame_rd;
  logic [TW-1:0] link_cur;
  logic [FW-1:0] dest_flags, parent_flags;

  ntask_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .nt_set    (flags_q[NT_BIT]),
    .dest_busy (dest_busy),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .act_call  (act_call),
    .act_int   (act_int),
    .act_tret  (act_tret),
    .act_nret  (act_nret),
    .act_fault (act_fault)
  );

  ntask_frame_mem #(.NTASK(NTASK), .DEPTH(STK_DEPTH), .DW(DW)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (act_int),
    .pop      (act_nret),
    .task_sel (cur_q),
    .wdata    ({flags_q, cmd_addr}),
    .rdata    (frame_rd),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  ntask_task_table #(.NTASK(NTASK), .FLAGS_INIT(FLAGS_INIT)) u_tbl (
    .clk          (clk),
    .rst          (rst),
    .cur_task     (cur_q),
    .dest_task    (cmd_task),
    .cur_flags    (flags_q),
    .call_we      (act_call),
    .tret_we      (act_tret),
    .link_of_cur  (link_cur),
    .dest_flags   (dest_flags),
    .parent_flags (parent_flags),
    .dest_busy    (dest_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      flags_q  <= FLAGS_INIT;
      resume_q <= '0;
      done_q   <= 1'b0;
      sw_q     <= 1'b0;
      nret_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q  <= act_call | act_int | act_tret | act_nret;
      sw_q    <= act_call | act_tret;
      nret_q  <= act_nret;
      fault_q <= act_fault;
      if (act_call) begin
        cur_q   <= cmd_task;
        flags_q <= dest_flags | NT_MASK;
      end else if (act_int) begin
        flags_q <= flags_q & ~ENTRY_CLR;
      end else if (act_tret) begin
        cur_q   <= link_cur;
        flags_q <= parent_flags;
      end else if (act_nret) begin
        flags_q  <= frame_rd[DW-1:AW];
        resume_q <= frame_rd[AW-1:0];
      end
    end
  end

  assign cur_task    = cur_q;
  assign flags       = flags_q;
  assign resume_addr = resume_q;
  assign done        = done_q;
  assign task_sw     = sw_q;
  assign norm_ret    = nret_q;
  assign fault       = fault_q;
endmodule

// File: rtl/ntask_ret_ctrl_chk.sv
module ntask_ret_ctrl_chk
  import ntask_pkg::*;
#(
  parameter int TW = 3,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [TW-1:0] cmd_task,
  input logic [TW-1:0] cur_task,
  input logic [31:0]   flags,
  input logic [AW-1:0] resume_addr,
  input logic          done,
  input logic          task_sw,
  input logic          norm_ret,
  input logic          fault
);
  // R11: the two outcome pulses never coincide
  p_excl_r11: assert property (@(posedge clk) disable iff (rst) !(task_sw && norm_ret));

  // R8: a rejected command is not acknowledged and leaves state alone
  p_fault_nodone_r8: assert property (@(posedge clk) disable iff (rst) fault |-> !done);
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(cur_task) && $stable(flags) && $stable(resume_addr)));

  // R5: a plain acknowledge (interrupt entry) leaves the handler flags cleared
  p_entry_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !task_sw && !norm_ret) |-> ((flags & ENTRY_CLR) == '0));

  // R1 / R2: a call either faults or enters the destination as nested
  p_call_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0) |=>
      (fault || (task_sw && flags[NT_BIT] && cur_task == $past(cmd_task))));

  // R3: a return with the nesting flag set is a task switch
  p_iret_nested_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && flags[NT_BIT]) |=> (task_sw && !norm_ret));

  // R4: a local return stays in the same task
  p_nret_stay_r4: assert property (@(posedge clk) disable iff (rst)
    norm_ret |-> $stable(cur_task));
endmodule

bind ntask_ret_ctrl ntask_ret_ctrl_chk #(.TW(TW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_task    (cmd_task),
  .cur_task    (cur_task),
  .flags       (flags),
  .resume_addr (resume_addr),
  .done        (done),
  .task_sw     (task_sw),
  .norm_ret    (norm_ret),
  .fault       (fault)
);

// File: tb/ntask_ret_ctrl_tb_top.sv
`timescale 1ns/1ps
module ntask_ret_ctrl_tb_top;
  localparam logic [31:0] INIT = 32'h0003_0102;
  localparam logic [31:0] NEST = 32'h0003_4102;
  localparam logic [31:0] HAND = 32'h0000_0002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [2:0]  cmd_task = 3'd0;
  logic [15:0] cmd_addr = 16'd0;
  logic [2:0]  cur_task;
  logic [31:0] flags;
  logic [15:0] resume_addr;
  logic        done, task_sw, norm_ret, fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ntask_ret_ctrl dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_task(cmd_task), .cmd_addr(cmd_addr), .cur_task(cur_task),
    .flags(flags), .resume_addr(resume_addr), .done(done),
    .task_sw(task_sw), .norm_ret(norm_ret), .fault(fault)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, leave the command on for one rising edge
  task automatic cmd(logic [1:0] op, logic [2:0] t, logic [15:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_task = t; cmd_addr = a;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "cur_task", 32'(cur_task), 0);
    chk("R12", "flags", flags, INIT);
    chk("R12", "resume", 32'(resume_addr), 0);
    chk("R12", "pulses", {28'd0, done, task_sw, norm_ret, fault}, 0);
  endtask

  task automatic t_nested_irq();
    cmd(2'd0, 3'd3, 16'h0);
    chk("R1", "cur after call", 32'(cur_task), 3);
    chk("R1", "sw/done after call", {30'd0, task_sw, done}, 3);
    chk("R2", "flags after call", flags, NEST);
    cmd(2'd1, 3'd0, 16'h01A0);
    chk("R5", "flags in handler", flags, HAND);
    chk("R11", "entry pulses", {28'd0, done, task_sw, norm_ret, fault}, 4'b1000);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R4", "local return pulse", {30'd0, norm_ret, task_sw}, 2'b10);
    chk("R4", "resume addr", 32'(resume_addr), 32'h01A0);
    chk("R4", "task kept", 32'(cur_task), 3);
    chk("R6", "flags restored", flags, NEST);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R3", "task return pulse", {30'd0, task_sw, norm_ret}, 2'b10);
    chk("R3", "back to caller", 32'(cur_task), 0);
    chk("R3", "resume unchanged", 32'(resume_addr), 32'h01A0);
    chk("R7", "caller flags", flags, INIT);
    @(negedge clk);
    chk("R11", "idle done", {31'd0, done}, 0);
  endtask

  task automatic t_chain();
    cmd(2'd0, 3'd3, 16'h0);
    cmd(2'd1, 3'd0, 16'h02C0);
    cmd(2'd0, 3'd5, 16'h0);
    chk("R2", "grandchild flags", flags, NEST);
    chk("R1", "grandchild task", 32'(cur_task), 5);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R7", "reloaded handler flags", flags, HAND);
    chk("R7", "resumed task", 32'(cur_task), 3);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R4", "handler local return", {30'd0, norm_ret, task_sw}, 2'b10);
    chk("R6", "nested flags back", flags, NEST);
    chk("R4", "resume addr chain", 32'(resume_addr), 32'h02C0);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R3", "unwound to 0", 32'(cur_task), 0);
  endtask

  task automatic t_stack_limits();
    for (int i = 1; i <= 4; i++) begin
      cmd(2'd1, 3'd0, 16'(i * 16));
      chk("R8", "push accepted", {31'd0, done}, 1);
    end
    cmd(2'd1, 3'd0, 16'h0050);
    chk("R8", "overflow fault", {30'd0, fault, done}, 2'b10);
    chk("R8", "flags after overflow", flags, HAND);
    for (int i = 4; i >= 1; i--) begin
      cmd(2'd2, 3'd0, 16'h0);
      chk("R8", "pop order", 32'(resume_addr), 32'(i * 16));
    end
    chk("R6", "flags after drain", flags, INIT);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R8", "underflow fault", {30'd0, fault, done}, 2'b10);
    chk("R8", "resume after underflow", 32'(resume_addr), 32'h0010);
    chk("R8", "flags after underflow", flags, INIT);
  endtask

  task automatic t_busy_call();
    cmd(2'd0, 3'd2, 16'h0);
    cmd(2'd0, 3'd0, 16'h0);
    chk("R9", "call to chain member", {30'd0, fault, task_sw}, 2'b10);
    chk("R9", "task after reject", 32'(cur_task), 2);
    cmd(2'd0, 3'd2, 16'h0);
    chk("R9", "call to self", {31'd0, fault}, 1);
    chk("R9", "flags after reject", flags, NEST);
    cmd(2'd2, 3'd0, 16'h0);
    chk("R3", "return from 2", 32'(cur_task), 0);
  endtask

  task automatic t_reserved();
    cmd(2'd3, 3'd4, 16'h0);
    chk("R10", "reserved fault", {30'd0, fault, done}, 2'b10);
    chk("R10", "task unchanged", 32'(cur_task), 0);
    chk("R10", "flags unchanged", flags, INIT);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nested_irq();
    t_chain();
    t_stack_limits();
    t_busy_call();
    t_reserved();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule